// File: doc/BRIEF.md
# Virtual IPI Delivery Engine

This engine carries out one inter-processor interrupt that a guest virtual CPU has written. It first expands the command into a set of destinations. A physically addressed directed command names one guest physical ID. A logically addressed command carries a bitmask of logical IDs. A broadcast covers every guest physical ID. The engine then visits those destinations one at a time in ascending order. For a logical destination, it first translates the logical ID through a logical ID table into a guest physical ID. It then looks up the target's entry in a physical ID table.

For each valid target, the engine first sets the vector's bit in the target's pending-request bitmap, using one set-bit write. In the next cycle it reads the target's running flag again. If the target is running, the engine rings a doorbell to the host core held in the entry. If the target is not running, the engine remembers that. A failed lookup ends the command at once with an exit subcause. There is one exception: an invalid physical entry met during a broadcast is skipped. When all destinations are finished, the command ends in one of two ways. It raises a "target not running" exit if any target was descheduled. Otherwise it gives a done pulse.

The surrounding logic owns the two tables and the bitmaps. Each table read returns its data one cycle after its enable.

The controller is a state machine with these states:
- IDLE waits for a command (transition *accept*).
- SCAN picks the lowest remaining destination and issues a table read (*pick*), or moves to FINISH when none are left (*drain*).
- LOG_RD checks the logical entry (*translate* to PHY_RD, or *log_fault* to REPORT).
- PHY_RD checks the physical entry and issues the pending write plus a fresh read (*deliver* to CHECK). An invalid entry takes *skip* back to SCAN during a broadcast, or *phys_fault* to REPORT otherwise.
- CHECK rings or records a miss (*next* to SCAN).
- FINISH and REPORT each emit one ending pulse and return to IDLE (*retire*).

Top module: `ipi_delivery_engine`

## Requirements
- R1: A command is taken only while `busy` is low. `busy` rises on the cycle after acceptance and stays high until the cycle after the done or exit pulse. `cmd_valid` asserted while busy has no effect on any write, doorbell or result.
- R2: How the destination set is formed depends on the mode. With `cmd_broadcast`=1 it is every physical ID 0..NUM_ID-1. With `cmd_logical`=1 it is the logical IDs whose bits are set in `cmd_dest`. Otherwise it is the single physical ID in `cmd_dest[ID_W-1:0]`. Destinations are handled in ascending order.
- R3: A logical entry whose valid bit is clear ends the command with `exit_code`=1.
- R4: A logical entry that is valid but whose backing-pointer-ok bit is clear ends the command with `exit_code`=2.
- R5: An invalid physical entry met by a directed command (logical or physical) ends the command with `exit_code`=3.
- R6: During a broadcast, invalid physical entries are skipped with no write, no doorbell and no exit.
- R7: Each valid target gets exactly one `pend_wr_en` cycle that carries its guest physical ID and the command vector. This write comes strictly before that target's running check and doorbell: the doorbell appears exactly one cycle after the write.
- R8: A target whose running flag is set gets one `db_valid` cycle that carries the host core number from its physical entry.
- R9: If any delivered target was not running, that target gets no doorbell. The command ends, after all destinations are finished, with `exit_code`=4.
- R10: When every destination was valid and running, the command ends with a single-cycle `done` and no `exit_valid`. `done` and `exit_valid` are never high together.
- R11: After a fatal lookup failure (codes 1 to 3) no later destination is written or rung. Only that first error is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_vector | input | VEC_W | Interrupt vector |
| cmd_dest | input | NUM_ID | Logical ID mask, or physical ID in low bits |
| cmd_logical | input | 1 | Logical addressing |
| cmd_broadcast | input | 1 | Broadcast to all physical IDs |
| busy | output | 1 | Command in progress |
| log_rd_en | output | 1 | Logical table read |
| log_rd_idx | output | ID_W | Logical ID to read |
| log_rd_valid | input | 1 | Entry valid (one cycle after read) |
| log_rd_bp_ok | input | 1 | Backing pointer usable |
| log_rd_phys_id | input | ID_W | Translated guest physical ID |
| phys_rd_en | output | 1 | Physical table read |
| phys_rd_idx | output | ID_W | Physical ID to read |
| phys_rd_valid | input | 1 | Entry valid |
| phys_rd_running | input | 1 | Target running flag |
| phys_rd_host | input | HOST_W | Host core number |
| pend_wr_en | output | 1 | Set one pending bit |
| pend_wr_target | output | ID_W | Target physical ID |
| pend_wr_vector | output | VEC_W | Bit to set |
| db_valid | output | 1 | Doorbell request |
| db_host | output | HOST_W | Host core to signal |
| done | output | 1 | Clean completion pulse |
| exit_valid | output | 1 | Exit pulse |
| exit_code | output | 3 | Exit subcause |

## Verification
If the destination mask is wrong, the engine writes the wrong set of targets, or writes them in the wrong order. This shows in the `pend_wr_target` sequence within a few cycles of acceptance. If the miss flag or the fault register is stale or lost, only the single ending pulse is wrong: done instead of exit 4, or the wrong code. So every scenario checks the exact ending pulse as well as the write and doorbell logs. If the ordering inside a destination is broken, the doorbell no longer trails its pending write by exactly one cycle, and the cycle-stamp comparison catches this.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

    typedef enum logic [2:0] {
        XC_NONE        = 3'd0,
        XC_BAD_LOG     = 3'd1,
        XC_BAD_BACKING = 3'd2,
        XC_BAD_PHYS    = 3'd3,
        XC_NOT_RUNNING = 3'd4
    } exit_code_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SCAN,
        S_LOG_RD,
        S_PHY_RD,
        S_CHECK,
        S_FINISH,
        S_REPORT
    } eng_state_e;

endpackage

// File: rtl/ipi_dest_picker.sv
// Lowest-set-bit selector: yields the next destination in ascending order.
module ipi_dest_picker #(
    parameter int N     = 8,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     mask,
    output logic             found,
    output logic [IDX_W-1:0] idx
);

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (mask[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/ipi_fault_tracker.sv
// Holds the first fatal subcause and the sticky "some target not running" flag.
module ipi_fault_tracker
    import ipi_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       fatal_set,
    input  exit_code_e fatal_code,
    input  logic       miss_set,
    output exit_code_e fatal_q,
    output logic       miss_q
);

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            fatal_q <= XC_NONE;
            miss_q  <= 1'b0;
        end else begin
            if (fatal_set && fatal_q == XC_NONE) begin
                fatal_q <= fatal_code;
            end
            if (miss_set) begin
                miss_q <= 1'b1;
            end
        end
    end

    // R11: a fatal code is a real error code, and only one is ever recorded
    a_r11_fatal_is_error: assert property (@(posedge clk) disable iff (!rst_n)
        fatal_set |-> fatal_code inside {XC_BAD_LOG, XC_BAD_BACKING, XC_BAD_PHYS});
    a_r11_single_fatal: assert property (@(posedge clk) disable iff (!rst_n)
        (fatal_q != XC_NONE && !clear) |-> !fatal_set);

endmodule

// File: rtl/ipi_delivery_engine.sv
module ipi_delivery_engine
    import ipi_pkg::*;
#(
    parameter int NUM_ID = 8,
    parameter int VEC_W  = 8,
    parameter int HOST_W = 4,
    localparam int ID_W  = $clog2(NUM_ID)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [VEC_W-1:0]  cmd_vector,
    input  logic [NUM_ID-1:0] cmd_dest,
    input  logic              cmd_logical,
    input  logic              cmd_broadcast,
    output logic              busy,
    output logic              log_rd_en,
    output logic [ID_W-1:0]   log_rd_idx,
    input  logic              log_rd_valid,
    input  logic              log_rd_bp_ok,
    input  logic [ID_W-1:0]   log_rd_phys_id,
    output logic              phys_rd_en,
    output logic [ID_W-1:0]   phys_rd_idx,
    input  logic              phys_rd_valid,
    input  logic              phys_rd_running,
    input  logic [HOST_W-1:0] phys_rd_host,
    output logic              pend_wr_en,
    output logic [ID_W-1:0]   pend_wr_target,
    output logic [VEC_W-1:0]  pend_wr_vector,
    output logic              db_valid,
    output logic [HOST_W-1:0] db_host,
    output logic              done,
    output logic              exit_valid,
    output logic [2:0]        exit_code
);

    eng_state_e        state_q, state_d;
    logic [VEC_W-1:0]  vec_q;
    logic [NUM_ID-1:0] mask_q;
    logic              logical_q;
    logic              bcast_q;
    logic [ID_W-1:0]   tgt_q;

    logic              pick_found;
    logic [ID_W-1:0]   pick_idx;
    logic              accept;
    logic              fatal_set;
    exit_code_e        fatal_code;
    logic              miss_set;
    exit_code_e        fatal_q;
    logic              miss_q;

    ipi_dest_picker #(.N(NUM_ID)) u_picker (
        .mask  (mask_q),
        .found (pick_found),
        .idx   (pick_idx)
    );

    ipi_fault_tracker u_faults (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (accept),
        .fatal_set  (fatal_set),
        .fatal_code (fatal_code),
        .miss_set   (miss_set),
        .fatal_q    (fatal_q),
        .miss_q     (miss_q)
    );

    assign accept = (state_q == S_IDLE) && cmd_valid;

    // Next-state and fault classification
    always_comb begin
        state_d    = state_q;
        fatal_set  = 1'b0;
        fatal_code = XC_NONE;
        miss_set   = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (cmd_valid) state_d = S_SCAN;                        // accept
            end
            S_SCAN: begin
                if (!pick_found)    state_d = S_FINISH;                 // drain
                else if (logical_q) state_d = S_LOG_RD;                 // pick
                else                state_d = S_PHY_RD;                 // pick
            end
            S_LOG_RD: begin
                if (!log_rd_valid) begin                                // log_fault
                    state_d    = S_REPORT;
                    fatal_set  = 1'b1;
                    fatal_code = XC_BAD_LOG;
                end else if (!log_rd_bp_ok) begin                       // log_fault
                    state_d    = S_REPORT;
                    fatal_set  = 1'b1;
                    fatal_code = XC_BAD_BACKING;
                end else begin
                    state_d = S_PHY_RD;                                 // translate
                end
            end
            S_PHY_RD: begin
                if (phys_rd_valid) begin
                    state_d = S_CHECK;                                  // deliver
                end else if (bcast_q) begin
                    state_d = S_SCAN;                                   // skip
                end else begin                                          // phys_fault
                    state_d    = S_REPORT;
                    fatal_set  = 1'b1;
                    fatal_code = XC_BAD_PHYS;
                end
            end
            S_CHECK: begin
                miss_set = !phys_rd_running;
                state_d  = S_SCAN;                                      // next
            end
            S_FINISH: state_d = S_IDLE;                                 // retire
            S_REPORT: state_d = S_IDLE;                                 // retire
            default:  state_d = S_IDLE;
        endcase
    end

    // State and command registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= S_IDLE;
            vec_q     <= '0;
            mask_q    <= '0;
            logical_q <= 1'b0;
            bcast_q   <= 1'b0;
            tgt_q     <= '0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                S_IDLE: begin
                    if (cmd_valid) begin
                        vec_q     <= cmd_vector;
                        bcast_q   <= cmd_broadcast;
                        logical_q <= cmd_logical && !cmd_broadcast;
                        if (cmd_broadcast)    mask_q <= '1;
                        else if (cmd_logical) mask_q <= cmd_dest;
                        else                  mask_q <= NUM_ID'(1) << cmd_dest[ID_W-1:0];
                    end
                end
                S_SCAN: begin
                    if (pick_found) begin
                        mask_q[pick_idx] <= 1'b0;
                        tgt_q            <= pick_idx;
                    end
                end
                S_LOG_RD: begin
                    tgt_q <= log_rd_phys_id;
                end
                default: begin
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy           = (state_q != S_IDLE);
        log_rd_en      = 1'b0;
        log_rd_idx     = pick_idx;
        phys_rd_en     = 1'b0;
        phys_rd_idx    = pick_idx;
        pend_wr_en     = 1'b0;
        pend_wr_target = tgt_q;
        pend_wr_vector = vec_q;
        db_valid       = 1'b0;
        db_host        = phys_rd_host;
        done           = 1'b0;
        exit_valid     = 1'b0;
        exit_code      = XC_NONE;
        unique case (state_q)
            S_IDLE: begin
            end
            S_SCAN: begin
                log_rd_en  = pick_found && logical_q;
                phys_rd_en = pick_found && !logical_q;
            end
            S_LOG_RD: begin
                phys_rd_en  = log_rd_valid && log_rd_bp_ok;
                phys_rd_idx = log_rd_phys_id;
            end
            S_PHY_RD: begin
                // set pending bit, and re-read the entry so the running flag is sampled afterwards
                pend_wr_en  = phys_rd_valid;
                phys_rd_en  = phys_rd_valid;
                phys_rd_idx = tgt_q;
            end
            S_CHECK: begin
                db_valid = phys_rd_running;
            end
            S_FINISH: begin
                exit_valid = miss_q;
                done       = !miss_q;
                exit_code  = miss_q ? XC_NOT_RUNNING : XC_NONE;
            end
            S_REPORT: begin
                exit_valid = 1'b1;
                exit_code  = fatal_q;
            end
            default: begin
            end
        endcase
    end

    // R7: a doorbell always follows its pending write by one cycle
    a_r7_pend_before_ring: assert property (@(posedge clk) disable iff (!rst_n)
        db_valid |-> $past(pend_wr_en));
    // R1: the engine is idle right after its ending pulse
    a_r1_idle_after_end: assert property (@(posedge clk) disable iff (!rst_n)
        (done || exit_valid) |=> !busy);
    // R10: a command ends in exactly one way
    a_r10_end_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && exit_valid));
    // R3: every exit carries a nonzero subcause
    a_r3_exit_coded: assert property (@(posedge clk) disable iff (!rst_n)
        exit_valid |-> exit_code != 3'd0);
    // R11: nothing is written or rung after an exit
    a_r11_quiet_after_exit: assert property (@(posedge clk) disable iff (!rst_n)
        exit_valid |=> !(pend_wr_en || db_valid));
    // R2: at most one table read per cycle
    a_r2_single_read: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({log_rd_en, phys_rd_en, db_valid}));

endmodule

// File: tb/ipi_delivery_engine_test.sv
`timescale 1ns/1ps
module ipi_delivery_engine_test;

    localparam int NUM_ID = 8;
    localparam int VEC_W  = 8;
    localparam int HOST_W = 4;
    localparam int ID_W   = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic              cmd_valid = 1'b0;
    logic [VEC_W-1:0]  cmd_vector = '0;
    logic [NUM_ID-1:0] cmd_dest = '0;
    logic              cmd_logical = 1'b0;
    logic              cmd_broadcast = 1'b0;
    logic              busy, log_rd_en, phys_rd_en, pend_wr_en, db_valid, done, exit_valid;
    logic [ID_W-1:0]   log_rd_idx, phys_rd_idx, pend_wr_target, log_rd_phys_id;
    logic              log_rd_valid, log_rd_bp_ok, phys_rd_valid, phys_rd_running;
    logic [HOST_W-1:0] phys_rd_host, db_host;
    logic [VEC_W-1:0]  pend_wr_vector;
    logic [2:0]        exit_code;

    ipi_delivery_engine #(.NUM_ID(NUM_ID), .VEC_W(VEC_W), .HOST_W(HOST_W)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_vector(cmd_vector),
        .cmd_dest(cmd_dest), .cmd_logical(cmd_logical), .cmd_broadcast(cmd_broadcast),
        .busy(busy), .log_rd_en(log_rd_en), .log_rd_idx(log_rd_idx),
        .log_rd_valid(log_rd_valid), .log_rd_bp_ok(log_rd_bp_ok), .log_rd_phys_id(log_rd_phys_id),
        .phys_rd_en(phys_rd_en), .phys_rd_idx(phys_rd_idx), .phys_rd_valid(phys_rd_valid),
        .phys_rd_running(phys_rd_running), .phys_rd_host(phys_rd_host),
        .pend_wr_en(pend_wr_en), .pend_wr_target(pend_wr_target), .pend_wr_vector(pend_wr_vector),
        .db_valid(db_valid), .db_host(db_host), .done(done), .exit_valid(exit_valid),
        .exit_code(exit_code)
    );

    // Tables and pending bitmaps
    logic              lt_valid [NUM_ID];
    logic              lt_bp    [NUM_ID];
    logic [ID_W-1:0]   lt_pid   [NUM_ID];
    logic              pt_valid [NUM_ID];
    logic              pt_run   [NUM_ID];
    logic [HOST_W-1:0] pt_host  [NUM_ID];
    logic [255:0]      pend_bm  [NUM_ID];

    always_ff @(posedge clk) begin
        if (log_rd_en) begin
            log_rd_valid   <= lt_valid[log_rd_idx];
            log_rd_bp_ok   <= lt_bp[log_rd_idx];
            log_rd_phys_id <= lt_pid[log_rd_idx];
        end
        if (phys_rd_en) begin
            phys_rd_valid   <= pt_valid[phys_rd_idx];
            phys_rd_running <= pt_run[phys_rd_idx];
            phys_rd_host    <= pt_host[phys_rd_idx];
        end
        if (pend_wr_en) pend_bm[pend_wr_target][pend_wr_vector] <= 1'b1;
    end

    // Event logs, sampled at the falling edge
    int cyc = 0;
    int pw_cnt, db_cnt, done_cnt, exit_cnt, last_code, busy_hi;
    int pw_tgt [16];
    int pw_vec [16];
    int pw_cyc [16];
    int db_h   [16];
    int db_cyc [16];
    int checks = 0;
    int fails  = 0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (busy) busy_hi++;
        if (pend_wr_en && pw_cnt < 16) begin
            pw_tgt[pw_cnt] = int'(pend_wr_target);
            pw_vec[pw_cnt] = int'(pend_wr_vector);
            pw_cyc[pw_cnt] = cyc;
            pw_cnt++;
        end
        if (db_valid && db_cnt < 16) begin
            db_h[db_cnt]   = int'(db_host);
            db_cyc[db_cnt] = cyc;
            db_cnt++;
        end
        if (done) done_cnt++;
        if (exit_valid) begin
            exit_cnt++;
            last_code = int'(exit_code);
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tables_default();
        for (int i = 0; i < NUM_ID; i++) begin
            lt_valid[i] = 1'b1;
            lt_bp[i]    = 1'b1;
            lt_pid[i]   = ID_W'(NUM_ID - 1 - i);
            pt_valid[i] = 1'b1;
            pt_run[i]   = 1'b1;
            pt_host[i]  = HOST_W'(i + 8);
        end
    endtask

    task automatic clear_logs();
        pw_cnt = 0; db_cnt = 0; done_cnt = 0; exit_cnt = 0; last_code = -1; busy_hi = 0;
    endtask

    task automatic wait_end();
        for (int k = 0; k < 200; k++) begin
            @(posedge clk);
            #1;
            if (done_cnt + exit_cnt != 0) break;
        end
        @(posedge clk);
        #1;
    endtask

    task automatic run_cmd(input int vec, input int dest, input bit lg, input bit bc);
        @(posedge clk);
        #1;
        clear_logs();
        cmd_valid = 1'b1; cmd_vector = VEC_W'(vec); cmd_dest = NUM_ID'(dest);
        cmd_logical = lg; cmd_broadcast = bc;
        @(posedge clk);
        #1;
        cmd_valid = 1'b0;
        wait_end();
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(!busy && !done && !exit_valid && !db_valid && !pend_wr_en, "R1 reset quiet",
            int'({busy, done, exit_valid, db_valid, pend_wr_en}), 0);
    endtask

    task automatic t_directed_ok();
        tables_default();
        run_cmd(8'h41, 3, 1'b0, 1'b0);
        chk(pw_cnt == 1 && pw_tgt[0] == 3 && pw_vec[0] == 8'h41, "R7 directed write", pw_tgt[0], 3);
        chk(db_cnt == 1 && db_h[0] == 11, "R8 directed doorbell host", db_h[0], 11);
        chk(db_cyc[0] == pw_cyc[0] + 1, "R7 write precedes doorbell", db_cyc[0], pw_cyc[0] + 1);
        chk(done_cnt == 1 && exit_cnt == 0, "R10 directed done", done_cnt, 1);
        chk(pend_bm[3][8'h41] == 1'b1, "R7 bitmap bit set", int'(pend_bm[3][8'h41]), 1);
    endtask

    task automatic t_logical_ok();
        tables_default();
        run_cmd(8'h22, 8'b0000_0101, 1'b1, 1'b0);
        chk(pw_cnt == 2 && pw_tgt[0] == 7 && pw_tgt[1] == 5, "R2 logical translate order",
            pw_tgt[1], 5);
        chk(db_cnt == 2 && db_h[0] == 15 && db_h[1] == 13, "R8 logical doorbells", db_h[1], 13);
        chk(done_cnt == 1, "R10 logical done", done_cnt, 1);
    endtask

    task automatic t_bad_log();
        tables_default();
        lt_valid[2] = 1'b0;
        run_cmd(8'h30, 8'b0000_1110, 1'b1, 1'b0);
        chk(exit_cnt == 1 && last_code == 1, "R3 invalid logical code", last_code, 1);
        chk(pw_cnt == 1 && pw_tgt[0] == 6, "R11 stop after first fault", pw_cnt, 1);
        chk(done_cnt == 0, "R11 no done on fault", done_cnt, 0);
    endtask

    task automatic t_bad_backing();
        tables_default();
        lt_bp[4] = 1'b0;
        run_cmd(8'h31, 8'b0001_0000, 1'b1, 1'b0);
        chk(exit_cnt == 1 && last_code == 2, "R4 bad backing code", last_code, 2);
        chk(pw_cnt == 0 && db_cnt == 0, "R4 nothing delivered", pw_cnt, 0);
    endtask

    task automatic t_bad_phys();
        tables_default();
        pt_valid[2] = 1'b0;
        run_cmd(8'h32, 2, 1'b0, 1'b0);
        chk(exit_cnt == 1 && last_code == 3, "R5 invalid physical code", last_code, 3);
        chk(pw_cnt == 0 && db_cnt == 0, "R5 nothing delivered", pw_cnt, 0);
    endtask

    task automatic t_bcast_mixed();
        tables_default();
        pt_valid[2] = 1'b0;
        pt_run[5]   = 1'b0;
        run_cmd(8'h55, 0, 1'b0, 1'b1);
        chk(pw_cnt == 7, "R6 broadcast skips invalid", pw_cnt, 7);
        chk(pw_tgt[0] == 0 && pw_tgt[2] == 3 && pw_tgt[6] == 7, "R2 broadcast ascending",
            pw_tgt[2], 3);
        chk(db_cnt == 6, "R9 no doorbell to stopped target", db_cnt, 6);
        chk(exit_cnt == 1 && last_code == 4 && done_cnt == 0, "R9 not running exit", last_code, 4);
    endtask

    task automatic t_bcast_ok();
        tables_default();
        run_cmd(8'h77, 0, 1'b0, 1'b1);
        chk(pw_cnt == 8 && db_cnt == 8, "R8 broadcast all rung", db_cnt, 8);
        chk(done_cnt == 1 && exit_cnt == 0, "R10 broadcast done", done_cnt, 1);
    endtask

    task automatic t_not_running();
        tables_default();
        pt_run[5] = 1'b0;
        run_cmd(8'h12, 5, 1'b0, 1'b0);
        chk(pw_cnt == 1 && pw_tgt[0] == 5, "R9 pending still set", pw_cnt, 1);
        chk(db_cnt == 0 && exit_cnt == 1 && last_code == 4, "R9 exit after delivery", last_code, 4);
    endtask

    task automatic t_busy_ignore();
        tables_default();
        @(posedge clk);
        #1;
        clear_logs();
        cmd_valid = 1'b1; cmd_vector = 8'h10; cmd_dest = 8'd1;
        cmd_logical = 1'b0; cmd_broadcast = 1'b0;
        @(posedge clk);
        #1;
        cmd_vector = 8'h99; cmd_dest = 8'd4;
        chk(busy == 1'b1, "R1 busy after accept", int'(busy), 1);
        for (int k = 0; k < 200; k++) begin
            if (done_cnt + exit_cnt != 0) break;
            @(posedge clk);
            #1;
        end
        cmd_valid = 1'b0;
        @(posedge clk);
        #1;
        chk(pw_cnt == 1 && pw_vec[0] == 8'h10, "R1 busy command ignored", pw_vec[0], 8'h10);
        chk(done_cnt == 1, "R1 single completion", done_cnt, 1);
        chk(busy == 1'b0 || pw_cnt == 1, "R1 idle after end", int'(busy), 0);
        // a command left asserted at the done cycle may be legally accepted; drain it
        wait_end();
        @(negedge clk);
        chk(busy == 1'b0, "R1 idle after drain", int'(busy), 0);
    endtask

    initial begin
        for (int i = 0; i < NUM_ID; i++) pend_bm[i] = '0;
        log_rd_valid = 1'b0; log_rd_bp_ok = 1'b0; log_rd_phys_id = '0;
        phys_rd_valid = 1'b0; phys_rd_running = 1'b0; phys_rd_host = '0;
        tables_default();
        clear_logs();
        repeat (4) @(posedge clk);
        #1;
        rst_n = 1'b1;
        t_reset();
        t_directed_ok();
        t_logical_ok();
        t_bad_log();
        t_bad_backing();
        t_bad_phys();
        t_bcast_mixed();
        t_bcast_ok();
        t_not_running();
        t_busy_ignore();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #100000;
        fails++;
        checks++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule